// File: doc/BRIEF.md
# Uncore Event Counter Bank

This block is a bank of eight 64-bit event counters that software reaches through a simple 32-bit register bus. Each counter is linked to an 8-bit event code, and the code picks one line out of a 256-line event input bus. On every clock where the block-wide enable, the counter's own enable and the chosen event line are all high, the counter goes up by one. One code has a fixed meaning: code 0x09 counts every clock cycle, whatever the event bus carries.

A counter that rolls over from all ones to zero sets its bit in an overflow status register. Software clears status bits by writing ones to a separate clear register. A mask register, in which a 1 blocks a bit, decides which status bits reach the single interrupt output. Software can read back a fixed version word. Each counter can be read and preloaded as two 32-bit halves. Read data is combinational from the address. A write takes effect on the clock edge on which the write strobe is high.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset, the global control (0x000), counter enable (0x004), both event-select registers, the status register (0x014) and every counter read 0. The interrupt mask (0x010) reads 0xFF. The interrupt output is low.
- R2: On a clock edge where bit 0 of 0x000 is 1, bit n of the counter enable register 0x004 is 1, and the event line indexed by counter n's code is high, counter n increases by exactly 1. Otherwise counter n holds its value, unless software writes it.
- R3: While bit 0 of the global control register 0x000 is 0, no counter changes, whatever the per-counter enables and event lines are. Only bit 0 of 0x000 is stored.
- R4: Counters 0 to 3 take their codes from the select register at 0x008, and counters 4 to 7 from the one at 0x00C. Counter n uses bits [8*(n mod 4)+7 : 8*(n mod 4)] of its register.
- R5: A counter whose code is 0x09 counts on every enabled cycle, whether or not event line 9 is high.
- R6: The low word of counter n is at 0x100+8n and the high word at 0x104+8n. A write replaces only that half. When a write and an increment reach the same counter on the same edge, the written value is kept and the increment is lost.
- R7: When counter n rolls over from all ones to zero, bit n of the status register 0x014 is set on the same edge.
- R8: Writing to the clear register 0x018 clears each status bit whose data bit is 1 and leaves the others unchanged. If a rollover of counter n and a clear of bit n fall on the same edge, bit n ends up set. The clear register reads 0.
- R9: The interrupt output is high exactly when some status bit is 1 and the matching bit of the mask register 0x010 is 0.
- R10: The version register 0x01C always reads the VERSION_ID parameter (default 0x00010300). Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 12 | Byte address of the register being read or written |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_in | input | 256 | Event lines, indexed by event code |
| irq | output | 1 | Overflow interrupt, high while any unmasked status bit is set |

## Verification
Two pairs of functions can land on the same clock edge. A counter can roll over in the same cycle that software clears its status bit, and a counter can be written in the same cycle that it would have counted. To provoke the first, the bench preloads a counter with all ones and then raises its event line in the same cycle that it writes the clear. The status bit must read 1 afterwards, and a second clear, made with the event low, must then clear it. For the second, the bench writes a counter that counts every cycle and reads back the written value with nothing added. A behavioural model, updated on every edge, cross-checks the read data and the interrupt during a long random phase in which preloads near the rollover point mix with random register writes.

// File: rtl/ecb_pkg.sv
`timescale 1ns/1ps
package ecb_pkg;
  // register byte offsets; counter spacing and select-register spacing are fixed
  localparam logic [31:0] OFS_CTRL = 32'h000;
  localparam logic [31:0] OFS_CEN  = 32'h004;
  localparam logic [31:0] OFS_SEL0 = 32'h008;
  localparam logic [31:0] OFS_MASK = 32'h010;
  localparam logic [31:0] OFS_STAT = 32'h014;
  localparam logic [31:0] OFS_CLR  = 32'h018;
  localparam logic [31:0] OFS_VER  = 32'h01C;
  localparam logic [31:0] OFS_CNT  = 32'h100;
  localparam int CNT_STRIDE = 8;
  localparam int WORD_BYTES = 4;

  // bit position of a counter's code inside the concatenated select words
  function automatic int lane_lsb(int idx, int per_word, int code_w, int bus_w);
    return (idx / per_word) * bus_w + (idx % per_word) * code_w;
  endfunction

  // byte offset of the low (hi=0) or high (hi=1) half of counter idx
  function automatic logic [31:0] cnt_ofs(int idx, bit hi);
    return OFS_CNT + 32'(idx * CNT_STRIDE) + (hi ? 32'(WORD_BYTES) : 32'd0);
  endfunction

  // byte offset of select register s
  function automatic logic [31:0] sel_ofs(int s);
    return OFS_SEL0 + 32'(s * WORD_BYTES);
  endfunction
endpackage

// File: rtl/ecb_event_sel.sv
`timescale 1ns/1ps
module ecb_event_sel #(
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] CYCLE_CODE = 8'h09
) (
  input  logic [CODE_W-1:0]        code,
  input  logic [(1<<CODE_W)-1:0]   evt_in,
  output logic                     hit
);
  logic is_cycle;
  assign is_cycle = (code == CYCLE_CODE);
  assign hit      = is_cycle | evt_in[code];
endmodule

// File: rtl/ecb_counter.sv
`timescale 1ns/1ps
module ecb_counter #(
  parameter int CNT_W = 64,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [BUS_W-1:0] wdata,
  output logic [CNT_W-1:0] value,
  output logic             wrap
);
  localparam int HI_W = CNT_W - BUS_W;

  logic sw_write;
  assign sw_write = wr_lo | wr_hi;
  // rollover only when the increment actually lands
  assign wrap = inc & ~sw_write & (&value);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
    end else if (wr_lo) begin
      value[BUS_W-1:0] <= wdata;
    end else if (wr_hi) begin
      value[CNT_W-1:BUS_W] <= wdata[HI_W-1:0];
    end else if (inc) begin
      value <= value + 1'b1;
    end
  end
endmodule

// File: rtl/ecb_regs.sv
`timescale 1ns/1ps
module ecb_regs
  import ecb_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int NUM_SEL = 2,
  parameter int BUS_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [31:0]              addr32,
  input  logic [BUS_W-1:0]         wdata,
  input  logic [NUM_CNT-1:0]       wrap_vec,
  output logic                     glob_en,
  output logic [NUM_CNT-1:0]       cnt_en,
  output logic [NUM_SEL*BUS_W-1:0] sel_words,
  output logic [NUM_CNT-1:0]       int_mask,
  output logic [NUM_CNT-1:0]       ov_stat
);
  logic [NUM_CNT-1:0] clr_bits;
  assign clr_bits = (wr && addr32 == OFS_CLR) ? wdata[NUM_CNT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_en   <= 1'b0;
      cnt_en    <= '0;
      sel_words <= '0;
      int_mask  <= '1;
    end else if (wr) begin
      if (addr32 == OFS_CTRL) glob_en  <= wdata[0];
      if (addr32 == OFS_CEN)  cnt_en   <= wdata[NUM_CNT-1:0];
      if (addr32 == OFS_MASK) int_mask <= wdata[NUM_CNT-1:0];
      for (int s = 0; s < NUM_SEL; s++) begin
        if (addr32 == sel_ofs(s)) sel_words[s*BUS_W +: BUS_W] <= wdata;
      end
    end
  end

  // a new rollover outranks a clear on the same edge
  always_ff @(posedge clk) begin
    if (!rst_n) ov_stat <= '0;
    else        ov_stat <= (ov_stat & ~clr_bits) | wrap_vec;
  end
endmodule

// File: rtl/ecb_rdmux.sv
`timescale 1ns/1ps
module ecb_rdmux
  import ecb_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int NUM_SEL = 2,
  parameter int CNT_W   = 64,
  parameter int BUS_W   = 32,
  parameter logic [31:0] VERSION_ID = 32'h0001_0300
) (
  input  logic [31:0]              addr32,
  input  logic                     glob_en,
  input  logic [NUM_CNT-1:0]       cnt_en,
  input  logic [NUM_SEL*BUS_W-1:0] sel_words,
  input  logic [NUM_CNT-1:0]       int_mask,
  input  logic [NUM_CNT-1:0]       ov_stat,
  input  logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  output logic [BUS_W-1:0]         rdata
);
  localparam int HI_W = CNT_W - BUS_W;

  always_comb begin
    rdata = '0;
    if (addr32 == OFS_CTRL) rdata = BUS_W'(glob_en);
    if (addr32 == OFS_CEN)  rdata = BUS_W'(cnt_en);
    if (addr32 == OFS_MASK) rdata = BUS_W'(int_mask);
    if (addr32 == OFS_STAT) rdata = BUS_W'(ov_stat);
    if (addr32 == OFS_VER)  rdata = VERSION_ID;
    for (int s = 0; s < NUM_SEL; s++) begin
      if (addr32 == sel_ofs(s)) rdata = sel_words[s*BUS_W +: BUS_W];
    end
    for (int n = 0; n < NUM_CNT; n++) begin
      if (addr32 == cnt_ofs(n, 1'b0)) rdata = cnt_flat[n*CNT_W +: BUS_W];
      if (addr32 == cnt_ofs(n, 1'b1)) rdata = BUS_W'(cnt_flat[n*CNT_W+BUS_W +: HI_W]);
    end
  end
endmodule

// File: rtl/evt_counter_bank.sv
`timescale 1ns/1ps
module evt_counter_bank
  import ecb_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 64,
  parameter int CODE_W  = 8,
  parameter int ADDR_W  = 12,
  parameter int BUS_W   = 32,
  parameter logic [CODE_W-1:0] CYCLE_CODE = 8'h09,
  parameter logic [31:0] VERSION_ID = 32'h0001_0300
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [BUS_W-1:0]         reg_wdata,
  output logic [BUS_W-1:0]         reg_rdata,
  input  logic [(1<<CODE_W)-1:0]   evt_in,
  output logic                     irq
);
  localparam int CODES_PER_SEL = BUS_W / CODE_W;
  localparam int NUM_SEL       = (NUM_CNT + CODES_PER_SEL - 1) / CODES_PER_SEL;

  logic [31:0]              addr32;
  logic                     glob_en;
  logic [NUM_CNT-1:0]       cnt_en;
  logic [NUM_SEL*BUS_W-1:0] sel_words;
  logic [NUM_CNT-1:0]       int_mask;
  logic [NUM_CNT-1:0]       ov_stat;
  logic [NUM_CNT-1:0]       wrap_vec;
  logic [NUM_CNT-1:0]       hit_vec;
  logic [NUM_CNT-1:0]       inc_vec;
  logic [NUM_CNT-1:0]       wr_lo;
  logic [NUM_CNT-1:0]       wr_hi;
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;

  assign addr32 = {{(32-ADDR_W){1'b0}}, reg_addr};

  ecb_regs #(.NUM_CNT(NUM_CNT), .NUM_SEL(NUM_SEL), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr32(addr32), .wdata(reg_wdata),
    .wrap_vec(wrap_vec), .glob_en(glob_en), .cnt_en(cnt_en),
    .sel_words(sel_words), .int_mask(int_mask), .ov_stat(ov_stat)
  );

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    localparam int LSB = lane_lsb(n, CODES_PER_SEL, CODE_W, BUS_W);
    logic [CODE_W-1:0] code;
    assign code = sel_words[LSB +: CODE_W];

    ecb_event_sel #(.CODE_W(CODE_W), .CYCLE_CODE(CYCLE_CODE)) u_sel (
      .code(code), .evt_in(evt_in), .hit(hit_vec[n])
    );

    assign inc_vec[n] = glob_en & cnt_en[n] & hit_vec[n];
    assign wr_lo[n]   = reg_wr && (addr32 == cnt_ofs(n, 1'b0));
    assign wr_hi[n]   = reg_wr && (addr32 == cnt_ofs(n, 1'b1));

    ecb_counter #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .inc(inc_vec[n]), .wr_lo(wr_lo[n]),
      .wr_hi(wr_hi[n]), .wdata(reg_wdata),
      .value(cnt_flat[n*CNT_W +: CNT_W]), .wrap(wrap_vec[n])
    );
  end

  ecb_rdmux #(.NUM_CNT(NUM_CNT), .NUM_SEL(NUM_SEL), .CNT_W(CNT_W), .BUS_W(BUS_W),
              .VERSION_ID(VERSION_ID)) u_rd (
    .addr32(addr32), .glob_en(glob_en), .cnt_en(cnt_en), .sel_words(sel_words),
    .int_mask(int_mask), .ov_stat(ov_stat), .cnt_flat(cnt_flat), .rdata(reg_rdata)
  );

  assign irq = |(ov_stat & ~int_mask);
endmodule

// File: rtl/ecb_checker.sv
`timescale 1ns/1ps
module ecb_checker
  import ecb_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 64,
  parameter int BUS_W   = 32,
  parameter logic [31:0] VERSION_ID = 32'h0001_0300
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_wr,
  input logic [31:0]              addr32,
  input logic [BUS_W-1:0]         reg_wdata,
  input logic [BUS_W-1:0]         reg_rdata,
  input logic                     irq,
  input logic                     glob_en,
  input logic [NUM_CNT-1:0]       wrap_vec,
  input logic [NUM_CNT-1:0]       ov_stat,
  input logic [NUM_CNT-1:0]       inc_vec,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_vec[0] && !reg_wr) |=> (cnt_flat[CNT_W-1:0] == $past(cnt_flat[CNT_W-1:0]) + 1'b1));

  assert_global_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && !reg_wr) |=> $stable(cnt_flat));

  assert_wrap_sets_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_vec != '0) |=> ((ov_stat & $past(wrap_vec)) == $past(wrap_vec)));

  assert_clear_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && addr32 == OFS_CLR && wrap_vec == '0)
      |=> ((ov_stat & $past(reg_wdata[NUM_CNT-1:0])) == '0));

  assert_full_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && addr32 == OFS_MASK && (&reg_wdata[NUM_CNT-1:0])) |=> !irq);

  assert_version_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr32 == OFS_VER) |-> (reg_rdata == VERSION_ID));
endmodule

bind evt_counter_bank ecb_checker #(
  .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .BUS_W(BUS_W), .VERSION_ID(VERSION_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .addr32(addr32),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .glob_en(glob_en),
  .wrap_vec(wrap_vec), .ov_stat(ov_stat), .inc_vec(inc_vec), .cnt_flat(cnt_flat)
);

// File: tb/sim_evt_counter_bank.sv
`timescale 1ns/1ps
module sim_evt_counter_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [11:0]  reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [255:0] evt_in = '0;
  logic         irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  bit live = 0;

  always #10 clk = ~clk;

  evt_counter_bank u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq)
  );

  // behavioural reference state
  longint unsigned m_cnt [8];
  logic        m_gen;
  logic [7:0]  m_cen, m_mask, m_stat;
  logic [31:0] m_sel [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_cnt[k]) m_cnt[k] = 0;
      m_gen = 0; m_cen = 0; m_mask = 8'hFF; m_stat = 0;
      m_sel[0] = 0; m_sel[1] = 0;
    end else begin
      logic [7:0] wraps, clr;
      wraps = 0;
      for (int n = 0; n < 8; n++) begin
        logic [7:0] code;
        bit hit;
        code = m_sel[n / 4][(n % 4) * 8 +: 8];
        hit = (code == 8'h09) || evt_in[code];
        if (reg_wr && reg_addr == 12'(256 + 8 * n))
          m_cnt[n] = {m_cnt[n][63:32], reg_wdata};
        else if (reg_wr && reg_addr == 12'(260 + 8 * n))
          m_cnt[n] = {reg_wdata, m_cnt[n][31:0]};
        else if (m_gen && m_cen[n] && hit) begin
          if (m_cnt[n] == 64'hFFFF_FFFF_FFFF_FFFF) wraps[n] = 1'b1;
          m_cnt[n] = m_cnt[n] + 1;
        end
      end
      clr = (reg_wr && reg_addr == 12'h018) ? reg_wdata[7:0] : 8'h00;
      m_stat = (m_stat & ~clr) | wraps;
      if (reg_wr) begin
        case (reg_addr)
          12'h000: m_gen = reg_wdata[0];
          12'h004: m_cen = reg_wdata[7:0];
          12'h008: m_sel[0] = reg_wdata;
          12'h00C: m_sel[1] = reg_wdata;
          12'h010: m_mask = reg_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(logic [11:0] a);
    if (a >= 12'h100 && a < 12'h140) begin
      int n;
      n = int'(a[5:3]);
      return a[2] ? m_cnt[n][63:32] : m_cnt[n][31:0];
    end
    case (a)
      12'h000: return {31'b0, m_gen};
      12'h004: return {24'b0, m_cen};
      12'h008: return m_sel[0];
      12'h00C: return m_sel[1];
      12'h010: return {24'b0, m_mask};
      12'h014: return {24'b0, m_stat};
      12'h01C: return 32'h0001_0300;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [11:0] a);
    if (a >= 12'h100 && a < 12'h140) return "R6";
    case (a)
      12'h000: return "R3";
      12'h004: return "R2";
      12'h008, 12'h00C: return "R4";
      12'h010: return "R9";
      12'h014: return "R7";
      12'h018: return "R8";
      12'h01C: return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model, well away from the active edge
  always @(negedge clk) begin
    if (live && rst_n) begin
      logic [31:0] e;
      logic ei;
      e  = m_read(reg_addr);
      ei = |(m_stat & ~m_mask);
      check(reg_rdata == e, tag_of(reg_addr), 64'(reg_rdata), 64'(e));
      check(irq == ei, "R9", 64'(irq), 64'(ei));
    end
  end

  // all tasks enter and leave 2 ns after a rising edge
  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic expect_rd(logic [11:0] a, logic [31:0] exp, string tag);
    reg_addr = a;
    #5;
    check(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
    @(posedge clk); #2;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    live = 1;
    // R1: reset values
    expect_rd(12'h000, 32'h0, "R1");
    expect_rd(12'h004, 32'h0, "R1");
    expect_rd(12'h008, 32'h0, "R1");
    expect_rd(12'h010, 32'hFF, "R1");
    expect_rd(12'h014, 32'h0, "R1");
    expect_rd(12'h138, 32'h0, "R1");
    check(irq == 1'b0, "R1", 64'(irq), 64'h0);
    // R10: version fixed, write ignored
    bus_wr(12'h01C, 32'hDEAD_BEEF);
    expect_rd(12'h01C, 32'h0001_0300, "R10");
    // R4: codes c3=05 c2=C8 c1=09 c0=05 ; c7=11 c6=FF c5=09 c4=07
    bus_wr(12'h008, 32'h05C8_0905);
    bus_wr(12'h00C, 32'h11FF_0907);
    bus_wr(12'h004, 32'h0000_00FF);
    // R3: global enable off, events present, nothing counts
    evt_in = '1;
    idle(5);
    expect_rd(12'h100, 32'h0, "R3");
    expect_rd(12'h108, 32'h0, "R3");
    evt_in = '0;
    bus_wr(12'h000, 32'h1);
    // R5: counter 1 and 5 count cycles with no event lines
    idle(4);
    check(u0.reg_rdata == reg_rdata, "R5", 0, 0);
    reg_addr = 12'h108;
    #5;
    check(reg_rdata != 32'h0, "R5", 64'(reg_rdata), 64'h1);
    @(posedge clk); #2;
    expect_rd(12'h100, 32'h0, "R2");
    // R2/R4: pulse event 5 three times -> counters 0 and 3 count 3
    for (int i = 0; i < 3; i++) begin
      evt_in[5] = 1'b1; idle(1); evt_in[5] = 1'b0; idle(1);
    end
    expect_rd(12'h100, 32'h3, "R2");
    expect_rd(12'h118, 32'h3, "R4");
    expect_rd(12'h110, 32'h0, "R4");
    // R6: write wins over increment on a cycle counter
    bus_wr(12'h108, 32'h0000_0100);
    expect_rd(12'h108, 32'h0000_0100, "R6");
    // R7: preload counter 2 near the top and roll it over
    bus_wr(12'h114, 32'hFFFF_FFFF);
    bus_wr(12'h110, 32'hFFFF_FFFE);
    evt_in[200] = 1'b1; idle(2); evt_in[200] = 1'b0;
    expect_rd(12'h110, 32'h0, "R7");
    expect_rd(12'h014, 32'h4, "R7");
    check(irq == 1'b0, "R9", 64'(irq), 64'h0);
    // R9: unmask bit 2
    bus_wr(12'h010, 32'hFB);
    check(irq == 1'b1, "R9", 64'(irq), 64'h1);
    // R8: clear bit 0 only, status bit 2 remains
    bus_wr(12'h018, 32'h01);
    expect_rd(12'h014, 32'h4, "R8");
    bus_wr(12'h018, 32'h04);
    expect_rd(12'h014, 32'h0, "R8");
    check(irq == 1'b0, "R9", 64'(irq), 64'h0);
    // R8: rollover and clear on the same edge, rollover wins
    bus_wr(12'h114, 32'hFFFF_FFFF);
    bus_wr(12'h110, 32'hFFFF_FFFF);
    evt_in[200] = 1'b1;
    bus_wr(12'h018, 32'h04);
    evt_in[200] = 1'b0;
    expect_rd(12'h014, 32'h4, "R8");
    bus_wr(12'h018, 32'h04);
    expect_rd(12'h014, 32'h0, "R8");
    expect_rd(12'h018, 32'h0, "R8");
    // random phase, model compared every cycle
    for (int i = 0; i < 600; i++) begin
      int r;
      evt_in = {8{$urandom}};
      r = $urandom % 12;
      if (r == 0) begin
        logic [11:0] regs [6] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h018};
        bus_wr(regs[$urandom % 6], (r == 0 && ($urandom % 3 == 0)) ? 32'h1 : $urandom);
      end else if (r == 1) begin
        int k;
        k = $urandom % 8;
        bus_wr(12'(260 + 8 * k), 32'hFFFF_FFFF);
        bus_wr(12'(256 + 8 * k), 32'hFFFF_FFF0 | ($urandom % 16));
      end else begin
        reg_addr = 12'($urandom % 8) * 12'h4 + (($urandom % 2) != 0 ? 12'h100 : 12'h000);
        idle(1);
      end
    end
    evt_in = '0;
    idle(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule